// File: doc/BRIEF.md
# CPU-Cycle Interrupt Countdown Timer

This block is a 16-bit interrupt timer that counts down once per CPU bus cycle. Software first loads a 16-bit reload value one byte at a time through two register indices. It then writes a control register. That control write copies the reload value into the live counter, sets or clears the count enable, and acknowledges any pending interrupt, all at the same clock edge.

While counting, the live counter drops by one on each clock. It wraps from zero to all-ones rather than stopping. When the counter holds zero and counting is enabled, an active-high interrupt request is latched. It stays asserted until the next control write or a reset. A control write that enables counting while the live counter already holds zero raises the request at once. The top level of the chip may invert `irq_o` to drive an open-drain interrupt line.

Top module: `cpu_irq_timer`

## Requirements
- R1: After reset, `irq_o` is 0, the reload value and live counter are 0, and counting is stopped.
- R2: A write at index 0xB sets bits 7:0 of the reload value and a write at index 0xC sets bits 15:8. A write at index 0xA copies the reload value into the live counter.
- R3: Writes to the reload value never change the live counter while it runs.
- R4: A write at index 0xA takes data bit 0 as the count enable (1 runs, 0 stops) and ignores data bits 7:1. While stopped, the counter holds and no interrupt is raised from it.
- R5: Every write at index 0xA clears a pending interrupt, unless R7 applies to that write.
- R6: While enabled, the live counter decrements by one each clock. With a nonzero reload value L loaded by an enabling write at edge E, `irq_o` first rises at edge E+L+1, which is the edge after the counter holds zero.
- R7: A write at index 0xA with data bit 0 set raises `irq_o` at that same edge when the live counter, before the reload, holds zero.
- R8: Once raised, `irq_o` stays 1 until the next write at index 0xA or a reset, even after the counter wraps away from zero.
- R9: Writes at any index other than 0xA, 0xB or 0xC, and any cycle with `wr_en_i` low, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe for this cycle |
| reg_idx_i | input | 4 | Register index of the write |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the strobe, index and data are stable and known at each rising edge. They also assume that every write lasts exactly one cycle, so a control write and a reload-byte write never share an edge. The bench drives all inputs on the falling edge and drops the strobe after one rising edge. Before each enabling write it loads the counter through a disabling control write, so the counter value that the immediate-fire rule checks is always known to the bench.

// File: rtl/cpu_irq_timer_pkg.sv
package cpu_irq_timer_pkg;
  localparam int unsigned IDX_W   = 4;
  localparam logic [IDX_W-1:0] IDX_CTRL = 4'hA;
  localparam logic [IDX_W-1:0] IDX_LO   = 4'hB;
  localparam logic [IDX_W-1:0] IDX_HI   = 4'hC;
  localparam int unsigned EN_BIT  = 0;
endpackage

// File: rtl/cit_wr_decode.sv
module cit_wr_decode
  import cpu_irq_timer_pkg::*;
(
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             ctrl_wr_o,
  output logic             lo_wr_o,
  output logic             hi_wr_o
);
  always_comb begin
    ctrl_wr_o = wr_en_i && (idx_i == IDX_CTRL);
    lo_wr_o   = wr_en_i && (idx_i == IDX_LO);
    hi_wr_o   = wr_en_i && (idx_i == IDX_HI);
  end
endmodule

// File: rtl/cit_reload_latch.sv
module cit_reload_latch #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  latch_o
);
  logic [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_wr_i) lo_q <= data_i;
      if (hi_wr_i) hi_q <= data_i;
    end
  end

  assign latch_o = {hi_q, lo_q};

  assert_latch_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_wr_i || hi_wr_i) |=> $stable(latch_o));
  assert_lo_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> latch_o[DATA_W-1:0] == $past(data_i));
endmodule

// File: rtl/cit_down_counter.sv
module cit_down_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             en_bit_i,
  input  logic [CNT_W-1:0] latch_i,
  output logic             run_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // wraps to all-ones past zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      cnt_q <= latch_i;
      run_q <= en_bit_i;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run_o  = run_q;
  assign zero_o = (cnt_q == '0);

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> cnt_q == $past(latch_i));
  assert_decrement_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !ctrl_wr_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ctrl_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cit_irq_flag.sv
module cit_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic en_bit_i,
  input  logic run_i,
  input  logic zero_i,
  output logic irq_o
);
  logic irq_q;

  // zero_i is the pre-reload count on a control write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (ctrl_wr_i)        irq_q <= en_bit_i && zero_i;
    else if (run_i && zero_i)  irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !(en_bit_i && zero_i)) |=> !irq_q);
  assert_immediate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && en_bit_i && zero_i) |=> irq_q);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ctrl_wr_i) |=> irq_q);
  assert_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && zero_i && !ctrl_wr_i) |=> irq_q);
  assert_quiet_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !run_i && !ctrl_wr_i) |=> !irq_q);
endmodule

// File: rtl/cpu_irq_timer.sv
module cpu_irq_timer
  import cpu_irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o
);
  logic             ctrl_wr, lo_wr, hi_wr;
  logic [CNT_W-1:0] latch;
  logic             run, zero;
  logic             en_bit;

  assign en_bit = wr_data_i[EN_BIT];

  cit_wr_decode u_dec (
    .wr_en_i   (wr_en_i),
    .idx_i     (reg_idx_i),
    .ctrl_wr_o (ctrl_wr),
    .lo_wr_o   (lo_wr),
    .hi_wr_o   (hi_wr)
  );

  cit_reload_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_wr_i (lo_wr),
    .hi_wr_i (hi_wr),
    .data_i  (wr_data_i),
    .latch_o (latch)
  );

  cit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .en_bit_i  (en_bit),
    .latch_i   (latch),
    .run_o     (run),
    .zero_o    (zero)
  );

  cit_irq_flag u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .en_bit_i  (en_bit),
    .run_i     (run),
    .zero_i    (zero),
    .irq_o     (irq_o)
  );

  assert_one_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_wr, lo_wr, hi_wr}));
endmodule

// File: tb/sim_cpu_irq_timer.sv
module sim_cpu_irq_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 7;
  localparam logic [15:0] VEC_L [NVEC] = '{16'h0000, 16'h0001, 16'h0002, 16'h0005,
                                           16'h0020, 16'h0100, 16'h0102};
  localparam int VEC_D [NVEC] = '{0, 2, 3, 6, 33, 257, 259};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] idx = 4'h0;
  logic [7:0] data = 8'h00;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpu_irq_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .reg_idx_i(idx), .wr_data_i(data), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = en; idx = i; data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // edges from the last write edge until irq is high
  task automatic wait_irq(input int t0, input int lim, output int delta);
    while (!irq && (cyc - t0) < lim) @(negedge clk);
    delta = irq ? (cyc - t0) : -1;
  endtask

  task automatic load(input logic [15:0] v);
    wr(1'b1, 4'hB, v[7:0]);
    wr(1'b1, 4'hC, v[15:8]);
    wr(1'b1, 4'hA, 8'h00);
  endtask

  initial begin
    int t0, d;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", irq, 0);
    rst_n = 1'b1;
    // R1: counter at 0, stopped, so no irq while idle
    repeat (20) @(negedge clk);
    check("R1 idle after reset", irq, 0);
    // R7 with reset counter value: enable with zero counter
    wr(1'b1, 4'hA, 8'h01);
    check("R1 R7 zero counter after reset", irq, 1);

    // R2 R6 R7 vector table
    for (int k = 0; k < NVEC; k++) begin
      load(VEC_L[k]);
      check("R5 ack on load", irq, 0);
      wr(1'b1, 4'hA, 8'h01);
      t0 = cyc;
      wait_irq(t0, 400, d);
      check($sformatf("R2 R6 R7 latency L=%0h", VEC_L[k]), d, VEC_D[k]);
    end

    // R8 sticky through wrap, R5 ack
    load(16'd3);
    wr(1'b1, 4'hA, 8'h01);
    t0 = cyc;
    wait_irq(t0, 50, d);
    check("R6 latency L=3", d, 4);
    repeat (12) @(negedge clk);
    check("R8 sticky after wrap", irq, 1);
    wr(1'b1, 4'hA, 8'h00);
    check("R5 ack clears", irq, 0);
    repeat (10) @(negedge clk);
    check("R5 stays clear when stopped", irq, 0);

    // R3 latch write during count
    load(16'd20);
    wr(1'b1, 4'hA, 8'h01);
    t0 = cyc;
    repeat (4) @(negedge clk);
    wr(1'b1, 4'hB, 8'h02);
    wr(1'b1, 4'hC, 8'h00);
    wait_irq(t0, 100, d);
    check("R3 running counter untouched", d, 21);

    // R4 disabled with zero counter, upper bits ignored
    load(16'd0);
    wr(1'b1, 4'hA, 8'hFE);
    repeat (30) @(negedge clk);
    check("R4 stopped no irq", irq, 0);
    wr(1'b1, 4'hA, 8'h01);
    check("R4 R7 bit0 enables", irq, 1);

    // R9 other indices and strobe low
    load(16'd4);
    for (int i = 0; i < 16; i++)
      if (i < 10 || i > 12) wr(1'b1, 4'(i), 8'hFF);
    wr(1'b0, 4'hB, 8'h77);
    wr(1'b0, 4'hC, 8'h77);
    wr(1'b0, 4'hA, 8'h01);
    repeat (10) @(negedge clk);
    check("R9 strobe-low ctrl ignored", irq, 0);
    wr(1'b1, 4'hA, 8'h00);
    wr(1'b1, 4'hA, 8'h01);
    t0 = cyc;
    wait_irq(t0, 50, d);
    check("R9 latch unchanged by stray writes", d, 5);

    // R1 reset mid-run clears all
    load(16'h0100);
    wr(1'b1, 4'hA, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears irq", irq, 0);
    rst_n = 1'b1;
    wr(1'b1, 4'hA, 8'h01);
    check("R1 R7 counter zero after reset", irq, 1);
    wr(1'b1, 4'hA, 8'h00);
    wr(1'b1, 4'hA, 8'h01);
    check("R1 latch zero after reset", irq, 1);

    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule